// File: doc/BRIEF.md
# Banked Vector Base Register Unit

This block holds the exception vector base addresses of a processor core that runs in two security worlds. It keeps three base registers: one used while the core is in the Secure world, one used while it is in the Non-secure world, and one used by the monitor that switches between the worlds. Software reaches these registers through coprocessor register transfers. The block decodes each transfer from its operand fields, the privilege level, the security state and a write-lock pin. It answers with read data, or it raises an undefined-instruction flag when the access is not allowed.

The block also turns an exception kind into its branch target address. The target is the base register of the current world, the fixed high-vector base, or the monitor base, plus a fixed offset for each kind. Interrupts, fast interrupts and external aborts can each be sent to the monitor base by routing inputs. A reset always goes to address zero, or to the high-vector base when high vectors are on.

Reads, the undefined flag and the vector address are combinational. A register write takes effect at the rising clock edge on which the access is presented.

Top module: `vbr_unit`

## Requirements
- R1: An access selects a register only when op1 = 0, CRn = 12 and CRm = 0. op2 = 0 selects the world-banked base and op2 = 1 selects the monitor base. Any other field combination raises no undefined flag, reads 0 and changes no register.
- R2: A privileged access with `acc_nonsecure` = 0 reads or writes the Secure base. With `acc_nonsecure` = 1 it reads or writes the Non-secure base. The written value can be read on any later cycle.
- R3: An access with `acc_priv` = 0 to either register raises `acc_undef`, reads 0 and changes no register, whether it is a read or a write.
- R4: While `wr_lock` = 1, a Secure privileged write to the Secure base or to the monitor base raises `acc_undef` and leaves the register unchanged. Non-secure writes and all reads are not affected by `wr_lock`.
- R5: Any access to the monitor base with `acc_nonsecure` = 1 raises `acc_undef` and leaves the register unchanged.
- R6: Bits [4:0] of every register are stored as zero and always read back as zero. Bits [31:5] keep the written data.
- R7: After reset, all three registers hold zero.
- R8: The target is the selected base plus an offset of kind × 4. The kinds are coded as 1 undefined instruction, 2 supervisor/monitor call, 3 prefetch abort, 4 data abort, 6 IRQ and 7 FIQ.
- R9: For a kind that is not routed to the monitor, the base is the register of the current world (`acc_nonsecure`) when `hi_vec` = 0, and 0xFFFF0000 when `hi_vec` = 1.
- R10: IRQ (kind 6) with `route_irq`, FIQ (kind 7) with `route_fiq`, and prefetch or data abort (kinds 3, 4) with `exc_ext` and `route_ea` all use the monitor base. This holds whatever the value of `hi_vec`.
- R11: Reset (kind 0) targets 0x00000000, or 0xFFFF0000 when `hi_vec` = 1. Register contents and routing inputs have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | A coprocessor register transfer is presented this cycle |
| acc_write | input | 1 | 1 = write transfer, 0 = read transfer |
| acc_op1 | input | 3 | First opcode field |
| acc_crn | input | 4 | Primary register number |
| acc_crm | input | 4 | Secondary register number |
| acc_op2 | input | 3 | Second opcode field |
| acc_wdata | input | 32 | Write data |
| acc_priv | input | 1 | 1 = privileged mode, 0 = user mode |
| acc_nonsecure | input | 1 | Current security state, 1 = Non-secure |
| wr_lock | input | 1 | Blocks Secure writes to the Secure and monitor registers |
| acc_rdata | output | 32 | Read data, 0 when no register is read |
| acc_undef | output | 1 | Undefined-instruction indication for the transfer |
| exc_kind | input | 3 | Exception kind code |
| exc_ext | input | 1 | The abort is external |
| route_irq | input | 1 | Route IRQ to the monitor |
| route_fiq | input | 1 | Route FIQ to the monitor |
| route_ea | input | 1 | Route external aborts to the monitor |
| hi_vec | input | 1 | High vectors enabled |
| exc_addr | output | 32 | Exception branch target address |

## Verification
The hardest case to reach from the ports is a write that is refused. Its only sign is that a register holds its old value, and that value can be seen only through a later privileged read or through a vector address. Each refused write (user mode, write lock, Non-secure monitor access, undecoded fields) is therefore sent with data that differs from the stored value, and the register is read back through the correct bank before the next write. The routing tests load all three registers with distinct values first. That way a target address that came from the wrong base can never match by chance.

// File: rtl/vbr_pkg.sv
package vbr_pkg;

   // exception kind codes; the vector offset is the code times four
   typedef enum logic [2:0] {
      EXC_RESET = 3'd0,
      EXC_UNDEF = 3'd1,
      EXC_CALL  = 3'd2,
      EXC_PABT  = 3'd3,
      EXC_DABT  = 3'd4,
      EXC_RSVD  = 3'd5,
      EXC_IRQ   = 3'd6,
      EXC_FIQ   = 3'd7
   } exc_kind_e;

   localparam int NUM_BANKS = 3;
   localparam logic [1:0] BANK_SEC  = 2'd0;
   localparam logic [1:0] BANK_NSEC = 2'd1;
   localparam logic [1:0] BANK_MON  = 2'd2;

   typedef struct packed {
      logic       hit;
      logic       undef;
      logic       wr_en;
      logic [1:0] sel;
   } vbr_dec_t;

endpackage

// File: rtl/vbr_decode.sv
module vbr_decode
   import vbr_pkg::*;
#(
   parameter logic [2:0] SEL_OP1     = 3'd0,
   parameter logic [3:0] SEL_CRN     = 4'd12,
   parameter logic [3:0] SEL_CRM     = 4'd0,
   parameter logic [2:0] SEL_OP2_WLD = 3'd0,
   parameter logic [2:0] SEL_OP2_MON = 3'd1
) (
   input  logic       valid,
   input  logic       write,
   input  logic [2:0] op1,
   input  logic [3:0] crn,
   input  logic [3:0] crm,
   input  logic [2:0] op2,
   input  logic       priv,
   input  logic       nonsecure,
   input  logic       wr_lock,
   output vbr_dec_t   dec
);

   logic common_hit;
   logic hit_wld;
   logic hit_mon;
   logic deny;

   always_comb begin
      common_hit = valid && (op1 == SEL_OP1) && (crn == SEL_CRN) && (crm == SEL_CRM);
      hit_wld    = common_hit && (op2 == SEL_OP2_WLD);
      hit_mon    = common_hit && (op2 == SEL_OP2_MON);

      deny = !priv
          || (hit_mon && nonsecure)
          || (write && !nonsecure && wr_lock);

      dec.hit   = hit_wld || hit_mon;
      dec.undef = dec.hit && deny;
      dec.wr_en = dec.hit && write && !deny;
      if (hit_mon)        dec.sel = BANK_MON;
      else if (nonsecure) dec.sel = BANK_NSEC;
      else                dec.sel = BANK_SEC;
   end

endmodule

// File: rtl/vbr_bank.sv
module vbr_bank
   import vbr_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int VEC_ALIGN = 5,
   parameter int NREG      = NUM_BANKS
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [1:0]                  wr_sel,
   input  logic [ADDR_W-1:0]           wr_data,
   output logic [NREG-1:0][ADDR_W-1:0] regs_q
);

   localparam logic [ADDR_W-1:0] KEEP_MASK = {{(ADDR_W-VEC_ALIGN){1'b1}}, {VEC_ALIGN{1'b0}}};

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regs_q[g] <= '0;
         end else if (wr_en && (wr_sel == 2'(g))) begin
            regs_q[g] <= wr_data & KEEP_MASK;
         end
      end
   end

endmodule

// File: rtl/vbr_vecgen.sv
module vbr_vecgen
   import vbr_pkg::*;
#(
   parameter int                ADDR_W      = 32,
   parameter bit                HIVEC_EN    = 1'b1,
   parameter logic [ADDR_W-1:0] HI_VEC_BASE = ADDR_W'(32'hFFFF_0000)
) (
   input  logic [2:0]        kind,
   input  logic              ext_abort,
   input  logic              route_irq,
   input  logic              route_fiq,
   input  logic              route_ea,
   input  logic              hi_vec,
   input  logic              nonsecure,
   input  logic [ADDR_W-1:0] sec_base,
   input  logic [ADDR_W-1:0] nsec_base,
   input  logic [ADDR_W-1:0] mon_base,
   output logic [ADDR_W-1:0] addr
);

   logic              hi_eff;
   logic              to_mon;
   logic [ADDR_W-1:0] offset;
   logic [ADDR_W-1:0] world_base;

   if (HIVEC_EN) begin : g_hivec
      assign hi_eff = hi_vec;
   end else begin : g_lovec
      logic unused_hi;
      assign unused_hi = hi_vec;
      assign hi_eff    = 1'b0;
   end

   always_comb begin
      offset = {{(ADDR_W-5){1'b0}}, kind, 2'b00};
      to_mon = ((kind == EXC_IRQ) && route_irq)
            || ((kind == EXC_FIQ) && route_fiq)
            || (((kind == EXC_PABT) || (kind == EXC_DABT)) && ext_abort && route_ea);
      world_base = nonsecure ? nsec_base : sec_base;

      if (kind == EXC_RESET)  addr = hi_eff ? HI_VEC_BASE : '0;
      else if (to_mon)        addr = mon_base + offset;
      else if (hi_eff)        addr = HI_VEC_BASE + offset;
      else                    addr = world_base + offset;
   end

endmodule

// File: rtl/vbr_unit.sv
module vbr_unit
   import vbr_pkg::*;
#(
   parameter int                ADDR_W      = 32,
   parameter int                VEC_ALIGN   = 5,
   parameter bit                HIVEC_EN    = 1'b1,
   parameter logic [ADDR_W-1:0] HI_VEC_BASE = ADDR_W'(32'hFFFF_0000)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [2:0]        acc_op1,
   input  logic [3:0]        acc_crn,
   input  logic [3:0]        acc_crm,
   input  logic [2:0]        acc_op2,
   input  logic [ADDR_W-1:0] acc_wdata,
   input  logic              acc_priv,
   input  logic              acc_nonsecure,
   input  logic              wr_lock,
   output logic [ADDR_W-1:0] acc_rdata,
   output logic              acc_undef,
   input  logic [2:0]        exc_kind,
   input  logic              exc_ext,
   input  logic              route_irq,
   input  logic              route_fiq,
   input  logic              route_ea,
   input  logic              hi_vec,
   output logic [ADDR_W-1:0] exc_addr
);

   localparam logic [ADDR_W-1:0] ALIGN_MASK = {{(ADDR_W-VEC_ALIGN){1'b0}}, {VEC_ALIGN{1'b1}}};

   // elaboration-time parameter checks
   if (ADDR_W < 8) begin : g_bad_width
      $error("vbr_unit: ADDR_W must be at least 8");
   end
   if ((VEC_ALIGN < 5) || (VEC_ALIGN >= ADDR_W)) begin : g_bad_align
      $error("vbr_unit: VEC_ALIGN must cover the vector table and stay below ADDR_W");
   end
   if ((HI_VEC_BASE & ALIGN_MASK) != '0) begin : g_bad_hibase
      $error("vbr_unit: HI_VEC_BASE must be aligned to the vector table");
   end

   vbr_dec_t                         dec;
   logic [NUM_BANKS-1:0][ADDR_W-1:0] regs_q;

   vbr_decode i_decode (
      .valid     (acc_valid),
      .write     (acc_write),
      .op1       (acc_op1),
      .crn       (acc_crn),
      .crm       (acc_crm),
      .op2       (acc_op2),
      .priv      (acc_priv),
      .nonsecure (acc_nonsecure),
      .wr_lock   (wr_lock),
      .dec       (dec)
   );

   vbr_bank #(
      .ADDR_W    (ADDR_W),
      .VEC_ALIGN (VEC_ALIGN),
      .NREG      (NUM_BANKS)
   ) i_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (dec.wr_en),
      .wr_sel  (dec.sel),
      .wr_data (acc_wdata),
      .regs_q  (regs_q)
   );

   vbr_vecgen #(
      .ADDR_W      (ADDR_W),
      .HIVEC_EN    (HIVEC_EN),
      .HI_VEC_BASE (HI_VEC_BASE)
   ) i_vecgen (
      .kind      (exc_kind),
      .ext_abort (exc_ext),
      .route_irq (route_irq),
      .route_fiq (route_fiq),
      .route_ea  (route_ea),
      .hi_vec    (hi_vec),
      .nonsecure (acc_nonsecure),
      .sec_base  (regs_q[BANK_SEC]),
      .nsec_base (regs_q[BANK_NSEC]),
      .mon_base  (regs_q[BANK_MON]),
      .addr      (exc_addr)
   );

   always_comb begin
      acc_undef = dec.undef;
      acc_rdata = '0;
      if (dec.hit && !dec.undef && !acc_write) begin
         case (dec.sel)
            BANK_SEC:  acc_rdata = regs_q[BANK_SEC];
            BANK_NSEC: acc_rdata = regs_q[BANK_NSEC];
            default:   acc_rdata = regs_q[BANK_MON];
         endcase
      end
   end

endmodule

// File: rtl/vbr_unit_chk.sv
module vbr_unit_chk #(
   parameter int ADDR_W    = 32,
   parameter int VEC_ALIGN = 5
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   acc_valid,
   input logic                   acc_write,
   input logic [2:0]             acc_op1,
   input logic [3:0]             acc_crn,
   input logic [3:0]             acc_crm,
   input logic [2:0]             acc_op2,
   input logic [ADDR_W-1:0]      acc_wdata,
   input logic                   acc_priv,
   input logic                   acc_nonsecure,
   input logic [ADDR_W-1:0]      acc_rdata,
   input logic                   acc_undef,
   input logic [2:0]             exc_kind,
   input logic                   route_irq,
   input logic                   hi_vec,
   input logic [ADDR_W-1:0]      exc_addr,
   input logic [2:0][ADDR_W-1:0] regs_q
);

   logic sel_common;
   logic sel_wld;
   logic sel_mon;

   assign sel_common = acc_valid && (acc_op1 == 3'd0) && (acc_crn == 4'd12) && (acc_crm == 4'd0);
   assign sel_wld    = sel_common && (acc_op2 == 3'd0);
   assign sel_mon    = sel_common && (acc_op2 == 3'd1);

   // R3: user-mode transfers to a decoded register are refused
   a_r3_user_undef: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_wld || sel_mon) && !acc_priv |-> acc_undef);

   // R4: a refused write leaves every register unchanged
   a_r4_refused_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && acc_write && acc_undef |=> $stable(regs_q));

   // R5: the monitor register is closed to the Non-secure world
   a_r5_mon_ns_undef: assert property (@(posedge clk) disable iff (!rst_n)
      sel_mon && acc_nonsecure |-> acc_undef);

   // R6: low address bits always read back as zero
   a_r6_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
      acc_rdata[VEC_ALIGN-1:0] == '0);

   // R2: an accepted Secure write to the banked base lands in the Secure copy
   a_r2_sec_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      sel_wld && acc_write && !acc_nonsecure && !acc_undef
      |=> regs_q[0][ADDR_W-1:VEC_ALIGN] == $past(acc_wdata[ADDR_W-1:VEC_ALIGN]));

   // R10: a routed IRQ uses the monitor base
   a_r10_irq_monitor: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_kind == 3'd6) && route_irq |-> exc_addr == regs_q[2] + ADDR_W'(24));

   // R11: reset vector with low vectors is address zero
   a_r11_reset_low: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_kind == 3'd0) && !hi_vec |-> exc_addr == '0);

endmodule

bind vbr_unit vbr_unit_chk #(
   .ADDR_W    (ADDR_W),
   .VEC_ALIGN (VEC_ALIGN)
) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .acc_valid     (acc_valid),
   .acc_write     (acc_write),
   .acc_op1       (acc_op1),
   .acc_crn       (acc_crn),
   .acc_crm       (acc_crm),
   .acc_op2       (acc_op2),
   .acc_wdata     (acc_wdata),
   .acc_priv      (acc_priv),
   .acc_nonsecure (acc_nonsecure),
   .acc_rdata     (acc_rdata),
   .acc_undef     (acc_undef),
   .exc_kind      (exc_kind),
   .route_irq     (route_irq),
   .hi_vec        (hi_vec),
   .exc_addr      (exc_addr),
   .regs_q        (regs_q)
);

// File: tb/test_vbr_unit.sv
`timescale 1ns/1ps
module test_vbr_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic        acc_write = 1'b0;
   logic [2:0]  acc_op1 = '0;
   logic [3:0]  acc_crn = '0;
   logic [3:0]  acc_crm = '0;
   logic [2:0]  acc_op2 = '0;
   logic [31:0] acc_wdata = '0;
   logic        acc_priv = 1'b0;
   logic        acc_nonsecure = 1'b0;
   logic        wr_lock = 1'b0;
   logic [31:0] acc_rdata;
   logic        acc_undef;
   logic [2:0]  exc_kind = '0;
   logic        exc_ext = 1'b0;
   logic        route_irq = 1'b0;
   logic        route_fiq = 1'b0;
   logic        route_ea = 1'b0;
   logic        hi_vec = 1'b0;
   logic [31:0] exc_addr;

   int vectors = 0;
   int misses  = 0;

   // expected register contents kept by the bench
   logic [31:0] m_sec = '0, m_ns = '0, m_mon = '0;

   always #2.5 clk = ~clk;

   vbr_unit i_vbr_unit (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_op1(acc_op1), .acc_crn(acc_crn), .acc_crm(acc_crm), .acc_op2(acc_op2),
      .acc_wdata(acc_wdata), .acc_priv(acc_priv), .acc_nonsecure(acc_nonsecure),
      .wr_lock(wr_lock), .acc_rdata(acc_rdata), .acc_undef(acc_undef),
      .exc_kind(exc_kind), .exc_ext(exc_ext), .route_irq(route_irq),
      .route_fiq(route_fiq), .route_ea(route_ea), .hi_vec(hi_vec),
      .exc_addr(exc_addr)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      vectors++;
      if (got !== exp) begin
         misses++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // one transfer, driven at the falling edge, sampled 1 ns later, captured at the rising edge
   task automatic xfer(input bit wr, input logic [3:0] crn, input logic [3:0] crm,
                       input logic [2:0] op2, input logic [31:0] d, input bit pv,
                       input bit ns, input bit lk,
                       output logic [31:0] rd, output logic ud);
      @(negedge clk);
      acc_valid = 1'b1; acc_write = wr; acc_op1 = 3'd0;
      acc_crn = crn; acc_crm = crm; acc_op2 = op2; acc_wdata = d;
      acc_priv = pv; acc_nonsecure = ns; wr_lock = lk;
      #1;
      rd = acc_rdata; ud = acc_undef;
      @(posedge clk);
      #1;
      acc_valid = 1'b0; acc_write = 1'b0; wr_lock = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [2:0] op2, input bit ns, input logic [31:0] exp);
      logic [31:0] rd; logic ud;
      xfer(1'b0, 4'd12, 4'd0, op2, 32'h0, 1'b1, ns, 1'b0, rd, ud);
      chk(req, rd, exp);
      chk(req, {31'd0, ud}, 32'd0);
   endtask

   task automatic vec_chk(input string req, input logic [2:0] k, input bit ns, input bit hv,
                          input bit ext, input bit ri, input bit rf, input bit re,
                          input logic [31:0] exp);
      @(negedge clk);
      exc_kind = k; acc_nonsecure = ns; hi_vec = hv; exc_ext = ext;
      route_irq = ri; route_fiq = rf; route_ea = re;
      #1;
      chk(req, exc_addr, exp);
   endtask

   task automatic t_reset;
      rd_chk("R7 secure base after reset", 3'd0, 1'b0, 32'h0);
      rd_chk("R7 nonsecure base after reset", 3'd0, 1'b1, 32'h0);
      rd_chk("R7 monitor base after reset", 3'd1, 1'b0, 32'h0);
   endtask

   task automatic t_banks;
      logic [31:0] rd; logic ud;
      xfer(1'b1, 4'd12, 4'd0, 3'd0, 32'h1234_5660, 1'b1, 1'b0, 1'b0, rd, ud);
      chk("R2 secure write accepted", {31'd0, ud}, 32'd0);
      m_sec = 32'h1234_5660;
      xfer(1'b1, 4'd12, 4'd0, 3'd0, 32'hABCD_0080, 1'b1, 1'b1, 1'b0, rd, ud);
      chk("R2 nonsecure write accepted", {31'd0, ud}, 32'd0);
      m_ns = 32'hABCD_0080;
      rd_chk("R2 secure copy", 3'd0, 1'b0, m_sec);
      rd_chk("R2 nonsecure copy", 3'd0, 1'b1, m_ns);
   endtask

   task automatic t_lowbits;
      logic [31:0] rd; logic ud;
      xfer(1'b1, 4'd12, 4'd0, 3'd0, 32'h8765_433F, 1'b1, 1'b0, 1'b0, rd, ud);
      m_sec = 32'h8765_4320;
      rd_chk("R6 low bits dropped", 3'd0, 1'b0, m_sec);
   endtask

   task automatic t_user;
      logic [31:0] rd; logic ud;
      xfer(1'b0, 4'd12, 4'd0, 3'd0, 32'h0, 1'b0, 1'b0, 1'b0, rd, ud);
      chk("R3 user read undef", {31'd0, ud}, 32'd1);
      chk("R3 user read data", rd, 32'h0);
      xfer(1'b1, 4'd12, 4'd0, 3'd0, 32'hDEAD_0000, 1'b0, 1'b1, 1'b0, rd, ud);
      chk("R3 user write undef", {31'd0, ud}, 32'd1);
      rd_chk("R3 user write ignored", 3'd0, 1'b1, m_ns);
      xfer(1'b1, 4'd12, 4'd0, 3'd1, 32'hDEAD_0000, 1'b0, 1'b0, 1'b0, rd, ud);
      chk("R3 user monitor write undef", {31'd0, ud}, 32'd1);
      rd_chk("R3 user monitor write ignored", 3'd1, 1'b0, m_mon);
   endtask

   task automatic t_lock;
      logic [31:0] rd; logic ud;
      xfer(1'b1, 4'd12, 4'd0, 3'd0, 32'h1111_0000, 1'b1, 1'b0, 1'b1, rd, ud);
      chk("R4 locked secure write undef", {31'd0, ud}, 32'd1);
      rd_chk("R4 locked secure write ignored", 3'd0, 1'b0, m_sec);
      xfer(1'b1, 4'd12, 4'd0, 3'd1, 32'h3333_0000, 1'b1, 1'b0, 1'b1, rd, ud);
      chk("R4 locked monitor write undef", {31'd0, ud}, 32'd1);
      rd_chk("R4 locked monitor write ignored", 3'd1, 1'b0, m_mon);
      xfer(1'b1, 4'd12, 4'd0, 3'd0, 32'h2222_0000, 1'b1, 1'b1, 1'b1, rd, ud);
      chk("R4 nonsecure write under lock", {31'd0, ud}, 32'd0);
      m_ns = 32'h2222_0000;
      rd_chk("R4 nonsecure write landed", 3'd0, 1'b1, m_ns);
      xfer(1'b0, 4'd12, 4'd0, 3'd0, 32'h0, 1'b1, 1'b0, 1'b1, rd, ud);
      chk("R4 secure read under lock undef", {31'd0, ud}, 32'd0);
      chk("R4 secure read under lock data", rd, m_sec);
   endtask

   task automatic t_monitor;
      logic [31:0] rd; logic ud;
      xfer(1'b1, 4'd12, 4'd0, 3'd1, 32'h5555_5540, 1'b1, 1'b0, 1'b0, rd, ud);
      chk("R1 monitor write accepted", {31'd0, ud}, 32'd0);
      m_mon = 32'h5555_5540;
      rd_chk("R1 monitor readback", 3'd1, 1'b0, m_mon);
      rd_chk("R1 secure base untouched by monitor write", 3'd0, 1'b0, m_sec);
      xfer(1'b0, 4'd12, 4'd0, 3'd1, 32'h0, 1'b1, 1'b1, 1'b0, rd, ud);
      chk("R5 nonsecure monitor read undef", {31'd0, ud}, 32'd1);
      chk("R5 nonsecure monitor read data", rd, 32'h0);
      xfer(1'b1, 4'd12, 4'd0, 3'd1, 32'h6666_0000, 1'b1, 1'b1, 1'b0, rd, ud);
      chk("R5 nonsecure monitor write undef", {31'd0, ud}, 32'd1);
      rd_chk("R5 nonsecure monitor write ignored", 3'd1, 1'b0, m_mon);
      rd_chk("R5 nonsecure base untouched", 3'd0, 1'b1, m_ns);
   endtask

   task automatic t_decode_miss;
      logic [31:0] rd; logic ud;
      xfer(1'b1, 4'd12, 4'd0, 3'd2, 32'h7777_0000, 1'b1, 1'b0, 1'b0, rd, ud);
      chk("R1 op2=2 no undef", {31'd0, ud}, 32'd0);
      xfer(1'b1, 4'd13, 4'd0, 3'd0, 32'h7777_0000, 1'b1, 1'b0, 1'b0, rd, ud);
      chk("R1 crn=13 no undef", {31'd0, ud}, 32'd0);
      xfer(1'b1, 4'd12, 4'd1, 3'd1, 32'h7777_0000, 1'b0, 1'b1, 1'b0, rd, ud);
      chk("R1 crm=1 user no undef", {31'd0, ud}, 32'd0);
      xfer(1'b0, 4'd12, 4'd1, 3'd0, 32'h0, 1'b1, 1'b0, 1'b0, rd, ud);
      chk("R1 crm=1 read data", rd, 32'h0);
      rd_chk("R1 secure base after misses", 3'd0, 1'b0, m_sec);
      rd_chk("R1 monitor base after misses", 3'd1, 1'b0, m_mon);
   endtask

   task automatic t_vectors;
      vec_chk("R8 undef secure",  3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, m_sec + 32'h04);
      vec_chk("R8 call secure",   3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, m_sec + 32'h08);
      vec_chk("R8 pabt secure",   3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, m_sec + 32'h0C);
      vec_chk("R8 dabt secure",   3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, m_sec + 32'h10);
      vec_chk("R8 irq secure",    3'd6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, m_sec + 32'h18);
      vec_chk("R8 fiq secure",    3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, m_sec + 32'h1C);
      vec_chk("R9 undef nonsecure", 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, m_ns + 32'h04);
      vec_chk("R9 fiq nonsecure",   3'd7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, m_ns + 32'h1C);
   endtask

   task automatic t_hivec;
      vec_chk("R9 high undef",  3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'hFFFF_0004);
      vec_chk("R9 high fiq ns", 3'd7, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'hFFFF_001C);
      vec_chk("R9 high dabt",   3'd4, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'hFFFF_0010);
   endtask

   task automatic t_routing;
      vec_chk("R10 irq routed",       3'd6, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, m_mon + 32'h18);
      vec_chk("R10 fiq not routed",   3'd7, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, m_sec + 32'h1C);
      vec_chk("R10 fiq routed",       3'd7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, m_mon + 32'h1C);
      vec_chk("R10 ext dabt routed",  3'd4, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, m_mon + 32'h10);
      vec_chk("R10 ext pabt routed",  3'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, m_mon + 32'h0C);
      vec_chk("R10 int dabt kept",    3'd4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, m_ns + 32'h10);
      vec_chk("R10 irq routed hivec", 3'd6, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, m_mon + 32'h18);
      vec_chk("R10 undef unrouted",   3'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, m_sec + 32'h04);
   endtask

   task automatic t_reset_vec;
      vec_chk("R11 reset low",  3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_0000);
      vec_chk("R11 reset low ns", 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0000);
      vec_chk("R11 reset high", 3'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 32'hFFFF_0000);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset;
      t_banks;
      t_lowbits;
      t_user;
      t_lock;
      t_monitor;
      t_decode_miss;
      t_vectors;
      t_hivec;
      t_routing;
      t_reset_vec;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      vectors++;
      misses++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

endmodule